// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block is a register-mapped controller for a behavioural one-time-programmable array of 32-bit fuse words. Software uses a simple flat-offset bus port. It loads a word address and a data word, then writes a command into the control register. The command is a read, a program (burn) or a sense. A program command ORs the data into two neighbouring words, a primary and a redundant copy. The array can therefore only gain set bits. A read returns the OR of the two copies.

A sense command walks the lower logical words of the array, one word per clock. Each one is copied into a shadow cache that software reads in the upper part of the register window. The burn pulse is timed from a programmable cycle count. Three sticky controls guard the block:
- a program-disable bit that rejects every later burn;
- a write lock that freezes every register against software writes;
- a key-lockout input that makes the five private-key cache words read as all ones.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the control word (offset 0x000), the address (0x004), the read result (0x008) and every cache word (0x100 + 4*i) read as zero.
- R2: Writing command 1 (read) into control bits 1:0 keeps busy (control bit 8) high for exactly one cycle. After that, offset 0x008 holds array[N] | array[(N+1) mod WORDS], where N is the address register.
- R3: Command 2 (program) ORs the write-data register (0x00C) into both word N and word (N+1) mod WORDS. A bit that has been set never returns to 0.
- R4: A program command keeps busy high for exactly max(P,1) cycles, where P is the pulse register at offset 0x010.
- R5: Command 3 (sense) keeps busy high for SHADOW_N cycles and loads cache word i with array[i] | array[i+1], for i below SHADOW_N. The cache keeps that snapshot until the next sense. Cache offsets at or beyond SHADOW_N read as zero.
- R6: Control bit 26 is a power-down flag, written together with the command field. While it is set, read and program commands are dropped and the error flag (control bit 9) is set. A sense command still runs.
- R7: Writing 1 in bit 0 of offset 0x014 disables programming until reset. Writing 0 does not clear it. Later program commands are dropped and set the error flag.
- R8: Writing 1 in bit 0 of offset 0x018 makes every later software write to any register have no effect until reset.
- R9: Once key_lock has been high for at least one cycle, cache words KEY_BASE to KEY_BASE+4 read as 0xFFFFFFFF until reset. Other cache words are unaffected.
- R10: A control write while busy is ignored entirely, including the power-down bit. The command field reads back 0 when no command runs. An accepted command clears the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_lock | input | 1 | Private-key lockout request, latched sticky |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset in the register window (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| busy | output | 1 | High while a command runs |

## Verification
On every cycle the assertions check four things. No array bit ever clears. A burn never happens while power-down or program-disable is set. The three sticky controls never fall. A control write made while busy leaves the power-down flag unchanged. The bench sweeps every word of a 16-word array with overlapping patterns against an OR model. It must show, through scenarios, the values a read or sense returns, the exact busy lengths for several pulse settings, and that rejected commands leave the array untouched. It must also show that the cache is a snapshot rather than a live view, and that the key mask covers exactly five words.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

  localparam int unsigned DW        = 32;
  localparam int unsigned KEY_WORDS = 5;

  localparam int unsigned BIT_PD   = 26;
  localparam int unsigned BIT_ERR  = 9;
  localparam int unsigned BIT_BUSY = 8;

  localparam logic [9:0] OFS_CTRL  = 10'h000;
  localparam logic [9:0] OFS_ADDR  = 10'h004;
  localparam logic [9:0] OFS_RDAT  = 10'h008;
  localparam logic [9:0] OFS_WDAT  = 10'h00C;
  localparam logic [9:0] OFS_PULSE = 10'h010;
  localparam logic [9:0] OFS_PDIS  = 10'h014;
  localparam logic [9:0] OFS_WLOCK = 10'h018;
  localparam logic [9:0] OFS_CACHE = 10'h100;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_PROG  = 2'd2,
    CMD_SENSE = 2'd3
  } fuse_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_PROG,
    ST_SENSE
  } seq_state_e;

  // Control word as seen by software.
  function automatic logic [DW-1:0] pack_ctrl(logic [1:0] cmd, logic bsy,
                                              logic err, logic pd);
    logic [DW-1:0] w;
    w           = '0;
    w[1:0]      = cmd;
    w[BIT_BUSY] = bsy;
    w[BIT_ERR]  = err;
    w[BIT_PD]   = pd;
    return w;
  endfunction

  // Fuses can only gain set bits.
  function automatic logic [DW-1:0] burn_merge(logic [DW-1:0] old_w,
                                               logic [DW-1:0] new_w);
    return old_w | new_w;
  endfunction

  // A command is refused when power is down (read/program) or burning is disabled.
  function automatic logic cmd_refused(logic [1:0] cmd, logic pd, logic pdis);
    logic needs_power;
    needs_power = (cmd == CMD_READ) || (cmd == CMD_PROG);
    return (needs_power && pd) || ((cmd == CMD_PROG) && pdis);
  endfunction

  function automatic seq_state_e start_state(logic [1:0] cmd);
    case (cmd)
      CMD_READ:  return ST_READ;
      CMD_PROG:  return ST_PROG;
      CMD_SENSE: return ST_SENSE;
      default:   return ST_IDLE;
    endcase
  endfunction

  function automatic logic is_key_word(int unsigned idx, int unsigned base);
    return (idx >= base) && (idx < base + KEY_WORDS);
  endfunction

endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_fuse_pkg::*;
#(
  parameter int unsigned AW = 6,
  localparam int unsigned WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burn_en,
  input  logic [AW-1:0] burn_idx,
  input  logic [DW-1:0] burn_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_word
);

  logic [DW-1:0] mem [WORDS];
  logic [AW-1:0] burn_nxt;
  logic [AW-1:0] rd_nxt;

  assign burn_nxt = burn_idx + AW'(1);
  assign rd_nxt   = rd_idx + AW'(1);

  // Primary and redundant copies are burned together.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (burn_en) begin
      for (int i = 0; i < WORDS; i++) begin
        if (AW'(i) == burn_idx || AW'(i) == burn_nxt)
          mem[i] <= burn_merge(mem[i], burn_data);
      end
    end
  end

  assign rd_word = mem[rd_idx] | mem[rd_nxt];

  for (genvar g = 0; g < WORDS; g++) begin : g_mono
    assert_fuse_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(mem[g]) & ~mem[g]) == '0));
  end

endmodule

// File: rtl/otp_fuse_shadow.sv
module otp_fuse_shadow
  import otp_fuse_pkg::*;
#(
  parameter int unsigned SHADOW_N = 16,
  parameter int unsigned KEY_BASE = 8,
  localparam int unsigned SW = $clog2(SHADOW_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [SW-1:0] load_idx,
  input  logic [DW-1:0] load_data,
  input  logic          key_lock,
  input  logic [SW-1:0] rd_idx,
  output logic [DW-1:0] rd_word
);

  logic [DW-1:0] sh [SHADOW_N];
  logic          kl_q;
  logic          key_masked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SHADOW_N; i++) sh[i] <= '0;
    end else if (load_en) begin
      sh[load_idx] <= load_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) kl_q <= 1'b0;
    else if (key_lock) kl_q <= 1'b1;
  end

  assign key_masked = (kl_q || key_lock) && is_key_word(int'(rd_idx), KEY_BASE);
  assign rd_word    = key_masked ? '1 : sh[rd_idx];

  assert_key_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(kl_q) |-> kl_q);

endmodule

// File: rtl/otp_fuse_seq.sv
module otp_fuse_seq
  import otp_fuse_pkg::*;
#(
  parameter int unsigned AW       = 6,
  parameter int unsigned SHADOW_N = 16,
  parameter int unsigned PULSE_W  = 16,
  localparam int unsigned SW = $clog2(SHADOW_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr,
  input  logic [1:0]         ctrl_cmd,
  input  logic               ctrl_pd,
  input  logic               prog_dis,
  input  logic [PULSE_W-1:0] pulse,
  input  logic [AW-1:0]      addr,
  output logic               busy,
  output logic               err,
  output logic               pd,
  output logic [1:0]         cmd_field,
  output logic [AW-1:0]      arr_idx,
  output logic               burn_fire,
  output logic               rd_done,
  output logic               sense_load,
  output logic [SW-1:0]      sense_idx
);

  seq_state_e         state;
  logic [1:0]         cmd_q;
  logic               err_q;
  logic               pd_q;
  logic [PULSE_W-1:0] cnt;
  logic [SW-1:0]      sidx;
  logic [AW-1:0]      op_addr;

  logic ctrl_acc;
  logic cmd_start;
  logic cmd_reject;
  logic sense_last;

  function automatic logic pulse_ends(logic [PULSE_W-1:0] c);
    return c <= PULSE_W'(1);
  endfunction

  assign busy       = (state != ST_IDLE);
  assign ctrl_acc   = ctrl_wr && !busy;
  assign cmd_reject = ctrl_acc && (ctrl_cmd != CMD_IDLE) && cmd_refused(ctrl_cmd, ctrl_pd, prog_dis);
  assign cmd_start  = ctrl_acc && (ctrl_cmd != CMD_IDLE) && !cmd_refused(ctrl_cmd, ctrl_pd, prog_dis);
  assign burn_fire  = (state == ST_PROG) && pulse_ends(cnt);
  assign rd_done    = (state == ST_READ);
  assign sense_load = (state == ST_SENSE);
  assign sense_last = (sidx == SW'(SHADOW_N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cmd_q   <= CMD_IDLE;
      err_q   <= 1'b0;
      pd_q    <= 1'b0;
      cnt     <= '0;
      sidx    <= '0;
      op_addr <= '0;
    end else begin
      if (ctrl_acc) pd_q <= ctrl_pd;
      if (cmd_start) begin
        state   <= start_state(ctrl_cmd);
        cmd_q   <= ctrl_cmd;
        err_q   <= 1'b0;
        op_addr <= addr;
        cnt     <= pulse;
        sidx    <= '0;
      end else if (cmd_reject) begin
        err_q <= 1'b1;
      end
      case (state)
        ST_READ: begin
          state <= ST_IDLE;
          cmd_q <= CMD_IDLE;
        end
        ST_PROG: begin
          if (burn_fire) begin
            state <= ST_IDLE;
            cmd_q <= CMD_IDLE;
          end else begin
            cnt <= cnt - PULSE_W'(1);
          end
        end
        ST_SENSE: begin
          if (sense_last) begin
            state <= ST_IDLE;
            cmd_q <= CMD_IDLE;
          end else begin
            sidx <= sidx + SW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign err       = err_q;
  assign pd        = pd_q;
  assign cmd_field = cmd_q;
  assign sense_idx = sidx;
  assign arr_idx   = (state == ST_SENSE) ? AW'(sidx) : op_addr;

  assert_burn_powered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burn_fire |-> !pd_q);
  assert_burn_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burn_fire |-> !prog_dis);
  assert_idle_cmd_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd_q == CMD_IDLE));
  assert_busy_keeps_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr) |=> $stable(pd_q));
  assert_sense_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sense_load |-> (int'(sidx) < SHADOW_N));

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int unsigned AW       = 6,
  parameter int unsigned SHADOW_N = 16,
  parameter int unsigned KEY_BASE = 8,
  parameter int unsigned PULSE_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_lock,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [9:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        busy
);

  localparam int unsigned SW = $clog2(SHADOW_N);

  logic [AW-1:0]      addr_q;
  logic [DW-1:0]      wdat_q;
  logic [DW-1:0]      rdat_q;
  logic [PULSE_W-1:0] pulse_q;
  logic               pdis_q;
  logic               wlock_q;

  logic               aligned;
  logic               wr_ok;
  logic               wr_blocked;
  logic               ctrl_wr;
  logic               in_cache;
  logic [9:0]         cache_ofs;
  logic [7:0]         cache_word;
  logic               cache_hit;

  logic               seq_err;
  logic               seq_pd;
  logic [1:0]         seq_cmd;
  logic [AW-1:0]      arr_idx;
  logic               burn_fire;
  logic               rd_done;
  logic               sense_load;
  logic [SW-1:0]      sense_idx;
  logic [DW-1:0]      arr_word;
  logic [DW-1:0]      cache_word_val;

  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign wr_ok      = bus_sel && bus_we && aligned && !wlock_q;
  assign wr_blocked = bus_sel && bus_we && wlock_q;
  assign ctrl_wr    = wr_ok && (bus_addr == OFS_CTRL);
  assign in_cache   = (bus_addr >= OFS_CACHE);
  assign cache_ofs  = bus_addr - OFS_CACHE;
  assign cache_word = cache_ofs[9:2];
  assign cache_hit  = in_cache && (int'(cache_word) < SHADOW_N);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdat_q  <= '0;
      pulse_q <= '0;
      pdis_q  <= 1'b0;
      wlock_q <= 1'b0;
    end else if (wr_ok) begin
      case (bus_addr)
        OFS_ADDR:  addr_q  <= bus_wdata[AW-1:0];
        OFS_WDAT:  wdat_q  <= bus_wdata;
        OFS_PULSE: pulse_q <= bus_wdata[PULSE_W-1:0];
        OFS_PDIS:  pdis_q  <= pdis_q | bus_wdata[0];
        OFS_WLOCK: wlock_q <= wlock_q | bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdat_q <= '0;
    else if (rd_done) rdat_q <= arr_word;
  end

  otp_fuse_seq #(
    .AW(AW), .SHADOW_N(SHADOW_N), .PULSE_W(PULSE_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_cmd   (bus_wdata[1:0]),
    .ctrl_pd    (bus_wdata[BIT_PD]),
    .prog_dis   (pdis_q),
    .pulse      (pulse_q),
    .addr       (addr_q),
    .busy       (busy),
    .err        (seq_err),
    .pd         (seq_pd),
    .cmd_field  (seq_cmd),
    .arr_idx    (arr_idx),
    .burn_fire  (burn_fire),
    .rd_done    (rd_done),
    .sense_load (sense_load),
    .sense_idx  (sense_idx)
  );

  otp_fuse_array #(.AW(AW)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .burn_en   (burn_fire),
    .burn_idx  (arr_idx),
    .burn_data (wdat_q),
    .rd_idx    (arr_idx),
    .rd_word   (arr_word)
  );

  otp_fuse_shadow #(.SHADOW_N(SHADOW_N), .KEY_BASE(KEY_BASE)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (sense_load),
    .load_idx  (sense_idx),
    .load_data (arr_word),
    .key_lock  (key_lock),
    .rd_idx    (SW'(cache_word)),
    .rd_word   (cache_word_val)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (cache_hit) begin
        bus_rdata = cache_word_val;
      end else if (!in_cache) begin
        case (bus_addr)
          OFS_CTRL:  bus_rdata = pack_ctrl(seq_cmd, busy, seq_err, seq_pd);
          OFS_ADDR:  bus_rdata = {{(DW-AW){1'b0}}, addr_q};
          OFS_RDAT:  bus_rdata = rdat_q;
          OFS_WDAT:  bus_rdata = wdat_q;
          OFS_PULSE: bus_rdata = {{(DW-PULSE_W){1'b0}}, pulse_q};
          OFS_PDIS:  bus_rdata = {{(DW-1){1'b0}}, pdis_q};
          OFS_WLOCK: bus_rdata = {{(DW-1){1'b0}}, wlock_q};
          default:   bus_rdata = '0;
        endcase
      end
    end
  end

  assert_prog_dis_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pdis_q) |-> pdis_q);
  assert_wlock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wlock_q) |-> wlock_q);
  assert_locked_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> ($stable(addr_q) && $stable(wdat_q) && $stable(pulse_q)));

endmodule

// File: tb/test_otp_fuse_ctrl.sv
module test_otp_fuse_ctrl;

  localparam int AW = 4;
  localparam int NW = 16;
  localparam int SN = 8;
  localparam int KB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_lock = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        busy;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m [NW];
  logic [31:0] snap [SN];

  always #2 clk = ~clk;

  otp_fuse_ctrl #(.AW(AW), .SHADOW_N(SN), .KEY_BASE(KB), .PULSE_W(16)) i_otp_fuse_ctrl (
    .clk(clk), .rst_n(rst_n), .key_lock(key_lock), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
  );

  function automatic logic [31:0] logical(int a);
    return m[a % NW] | m[(a + 1) % NW];
  endfunction

  function automatic logic [31:0] pat(int a);
    return (32'h1 << (a + 4)) | (32'(a) << 24) | (32'h3 & 32'(a));
  endfunction

  function automatic logic [31:0] ctrl_val(int cmd, int bsy, int err, int pd);
    return 32'(cmd) | (32'(bsy) << 8) | (32'(err) << 9) | (32'(pd) << 26);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] ofs, logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ofs; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [9:0] ofs, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ofs;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] c;
    cyc = 0;
    forever begin
      rd(10'h000, c);
      if (!c[8] || cyc > 2000) break;
      cyc++;
    end
  endtask

  task automatic do_prog(int a, logic [31:0] d, int p, output int cyc);
    wr(10'h010, 32'(p));
    wr(10'h004, 32'(a));
    wr(10'h00C, d);
    wr(10'h000, 32'd2);
    wait_idle(cyc);
  endtask

  task automatic do_read(int a, output logic [31:0] v, output int cyc);
    wr(10'h004, 32'(a));
    wr(10'h000, 32'd1);
    wait_idle(cyc);
    rd(10'h008, v);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int c;
    for (int i = 0; i < NW; i++) m[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(10'h000, v); chk("R1 ctrl", v, 32'h0);
    rd(10'h004, v); chk("R1 addr", v, 32'h0);
    rd(10'h008, v); chk("R1 rdata", v, 32'h0);
    for (int i = 0; i < SN; i++) begin
      rd(10'(32'h100 + 4 * i), v); chk("R1 cache", v, 32'h0);
    end

    // R3/R4: program every word, pulse lengths swept
    for (int a = 0; a < NW; a++) begin
      int p;
      p = (a % 4 == 0) ? 0 : a;
      do_prog(a, pat(a), p, c);
      chk("R4 pulse busy", 32'(c), 32'((p < 1) ? 1 : p));
      m[a] = m[a] | pat(a);
      m[(a + 1) % NW] = m[(a + 1) % NW] | pat(a);
    end
    rd(10'h000, v); chk("R10 cmd cleared", v, 32'h0);

    // R2: read every word
    for (int a = 0; a < NW; a++) begin
      do_read(a, v, c);
      chk("R2 busy", 32'(c), 32'd1);
      chk("R2 value", v, logical(a));
    end

    // R3: zero burn and overlapping burn keep set bits
    do_prog(9, 32'h0, 2, c);
    do_read(9, v, c); chk("R3 zero burn", v, logical(9));
    do_prog(11, 32'h000F_0000, 1, c);
    m[11] |= 32'h000F_0000; m[12] |= 32'h000F_0000;
    do_read(10, v, c); chk("R3 redundant", v, logical(10));
    do_read(12, v, c); chk("R3 primary", v, logical(12));

    // R5: sense
    wr(10'h000, 32'd3);
    wait_idle(c); chk("R5 busy", 32'(c), 32'(SN));
    for (int i = 0; i < SN; i++) begin
      snap[i] = logical(i);
      rd(10'(32'h100 + 4 * i), v); chk("R5 cache", v, snap[i]);
    end
    rd(10'(32'h100 + 4 * SN), v); chk("R5 beyond", v, 32'h0);
    rd(10'h3FC, v); chk("R5 top", v, 32'h0);

    // R6: power-down blocks read and program
    do_read(4, v, c);
    wr(10'h004, 32'd3);
    wr(10'h000, 32'h0400_0001);
    rd(10'h000, v); chk("R6 read refused", v, ctrl_val(0, 0, 1, 1));
    rd(10'h008, v); chk("R6 rdata kept", v, logical(4));
    wr(10'h00C, 32'hFFFF_FFFF);
    wr(10'h000, 32'h0400_0002);
    rd(10'h000, v); chk("R6 prog refused", v, ctrl_val(0, 0, 1, 1));
    wr(10'h000, 32'h0400_0003);
    wait_idle(c); chk("R6 sense runs", 32'(c), 32'(SN));
    rd(10'h000, v); chk("R6 err cleared R10", v, ctrl_val(0, 0, 0, 1));
    wr(10'h000, 32'h0);
    rd(10'h000, v); chk("R6 pd off", v, 32'h0);
    do_read(3, v, c); chk("R6 array untouched", v, logical(3));

    // R10: control writes while busy
    do_prog(7, 32'h00F0_0000, 20, c);
    m[7] |= 32'h00F0_0000; m[8] |= 32'h00F0_0000;
    wr(10'h010, 32'd20); wr(10'h004, 32'd6); wr(10'h00C, 32'h0A00_0000);
    wr(10'h000, 32'd2);
    wr(10'h000, 32'h0400_0001);
    wait_idle(c); chk("R10 busy write ignored", 32'(c), 32'd19);
    m[6] |= 32'h0A00_0000; m[7] |= 32'h0A00_0000;
    rd(10'h000, v); chk("R10 ctrl after", v, 32'h0);
    do_read(6, v, c); chk("R10 burn kept", v, logical(6));

    // R9: key lockout, cache keeps snapshot
    rd(10'h100 + 10'(4 * KB), v); chk("R9 pre-lock", v, snap[KB]);
    key_lock = 1'b1; @(negedge clk); key_lock = 1'b0;
    for (int i = 0; i < SN; i++) begin
      rd(10'(32'h100 + 4 * i), v);
      chk("R9 mask", v, (i >= KB && i < KB + 5) ? 32'hFFFF_FFFF : snap[i]);
    end

    // R7: program disable
    wr(10'h014, 32'd1); wr(10'h014, 32'd0);
    rd(10'h014, v); chk("R7 sticky", v, 32'h1);
    wr(10'h004, 32'd10); wr(10'h00C, 32'hFFFF_0000);
    wr(10'h000, 32'd2);
    rd(10'h000, v); chk("R7 refused", v, ctrl_val(0, 0, 1, 0));
    do_read(10, v, c); chk("R7 array kept", v, logical(10));

    // R8: write lock
    wr(10'h018, 32'd1);
    rd(10'h018, v); chk("R8 lock set", v, 32'h1);
    wr(10'h004, 32'd3);
    rd(10'h004, v); chk("R8 addr frozen", v, 32'd10);
    wr(10'h000, 32'd3);
    rd(10'h000, v); chk("R8 cmd ignored", v, 32'h0);
    wr(10'h018, 32'd0);
    rd(10'h018, v); chk("R8 lock sticky", v, 32'h1);

    finish_run();
  end

endmodule